// File: doc/BRIEF.md
# Video line SDRAM write sequencer with blanking-gap refresh

This block takes a camera's grayscale pixel stream, one 8-bit pixel per clock, and stores every video line in an SDRAM as one full-page write burst. After power-up it brings the memory into service: a settle delay, a precharge of all banks, two auto-refresh cycles, and a mode register load that selects full-page bursts in sequential order. From then on it waits for a line-start pulse. On that pulse it opens the line's row in a single fixed bank and writes the line from column 0. After the last word it stops the burst and closes the row.

Refresh never interrupts a line. After each line a fixed number of auto-refresh commands is issued in the blanking gap, and then the block returns to idle. The memory's internal refresh row counter moves on from gap to gap. With 25 refreshes per gap, all 4096 rows are covered in roughly 164 lines, far inside the retention limit.

Two SDRAMs share the command, address and data pins and have one chip select each. Each line and the refreshes after it go to the memory that the read side is not using, as given by `rd_sel` at the line-start pulse. When the read side asks for a buffer switch, the block latches the address of the last word it wrote.

Top module: `sdram_line_writer`

## Requirements
- R1: After reset both chip selects stay high (no command) and `dq_oe` stays low for at least PWRUP_CYC cycles, and `dq_oe` is never high before initialization has completed.
- R2: Initialization issues, to both chips at once (`cs_n`=00), a PRECHARGE with addr[10]=1 (all banks), then two AUTO REFRESH commands, then a MODE REGISTER SET with addr=0x027. In that value bits [2:0]=111 select a full-page burst, bit 3=0 selects sequential order and bits [6:4]=010 select CAS latency 2. Each command is issued at least T_RP, T_RFC and T_RFC cycles after the one before it, in that order.
- R3: A `line_start` pulse seen in idle causes an ACTIVE in the next cycle, on bank 0 (ba=00). WRITE follows exactly T_RCD cycles after the ACTIVE, with addr=0 (column 0, no auto precharge). Commands are encoded on {ras_n,cas_n,we_n} with a chip select low: ACTIVE 011, WRITE 100, BURST TERMINATE 110, PRECHARGE 010, AUTO REFRESH 001, MODE SET 000.
- R4: If `line_start` is high in cycle n, the pixel on `pix_data` in cycle n+T_RCD+k is driven on `dq` with `dq_oe` high as burst word k (k=0 in the WRITE cycle). Each line has exactly LINE_WORDS consecutive words.
- R5: BURST TERMINATE comes in the cycle right after the last word, and PRECHARGE comes in the cycle after that, with addr[10]=0 (single bank).
- R6: After each line exactly REFS_PER_GAP AUTO REFRESH commands are issued. The first comes T_RP cycles after the PRECHARGE, and the rest follow T_RFC cycles apart. No other command is issued before the next line's ACTIVE.
- R7: The ACTIVE row address starts at 0 after reset, rises by one per line, and wraps from ROWS-1 to 0.
- R8: All commands of a line and of its refresh gap go only to chip !rd_sel, with `rd_sel` sampled at the `line_start` pulse. `cs_n[i]` low selects chip i, so rd_sel=0 gives cs_n=01. A change of `rd_sel` during the line has no effect.
- R9: In the cycle after `switch_req`, `last_addr` holds {row, column} of the most recently written word. It is 0 if nothing has been written yet, and it keeps its value when `switch_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and SDRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse that opens a video line |
| pix_data | input | DATA_W | Pixel stream, one pixel per clock |
| rd_sel | input | 1 | Chip currently owned by the read side |
| switch_req | input | 1 | Request to latch the last written address |
| cs_n | output | 2 | Chip selects, bit i low selects SDRAM i |
| ras_n | output | 1 | Row address strobe |
| cas_n | output | 1 | Column address strobe |
| we_n | output | 1 | Write enable |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Row, column or mode value |
| dq | output | DATA_W | Write data |
| dq_oe | output | 1 | Data output enable |
| last_addr | output | log2(ROWS)+log2(LINE_WORDS) | Latched {row, column} of the last written word |

## Verification
Some rules are checked on every cycle. A burst opens only with a WRITE to column 0. The data window closes only on a BURST TERMINATE, and a PRECHARGE of one bank always follows it. A refresh is always followed by an idle cycle. The latched address changes only on a switch request. Other behaviour can only be shown by the bench's scenarios, which check each command and its exact cycle against the line-start times: the init order and the mode value, the pixel-to-word alignment over whole lines, the refresh count and spacing in each gap, the row wrap, chip steering with `rd_sel` changed in mid-line, and the address latched before any write and after a line.

// File: rtl/sdram_line_writer.sv
module sdram_line_writer #(
  parameter int LINE_WORDS   = 1024,
  parameter int ROWS         = 4096,
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int PWRUP_CYC    = 20000,
  parameter int T_RP         = 2,
  parameter int T_RFC        = 8,
  parameter int T_MRD        = 2,
  parameter int T_RCD        = 2,
  parameter int CAS_LAT      = 2,
  parameter int REFS_PER_GAP = 25,
  parameter int BANK         = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              rd_sel,
  input  logic              switch_req,
  output logic [1:0]        cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq,
  output logic              dq_oe,
  output logic [$clog2(ROWS)+$clog2(LINE_WORDS)-1:0] last_addr
);
  localparam int COL_W     = $clog2(LINE_WORDS);
  localparam int ROW_CNT_W = $clog2(ROWS);
  localparam int LA_W      = ROW_CNT_W + COL_W;
  localparam int INIT_REFS = 2;
  localparam int CNT_W     = $clog2(PWRUP_CYC + T_RP + T_RFC + T_MRD + T_RCD + 1);
  localparam int RF_W      = $clog2(REFS_PER_GAP + INIT_REFS + 1);
  localparam logic [ADDR_W-1:0] MODE_VAL = ADDR_W'(CAS_LAT * 16 + 7);

  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_WR = 3'b100,
                         C_BST = 3'b110, C_PRE = 3'b010, C_REF = 3'b001,
                         C_MRS = 3'b000;

  typedef enum logic [3:0] {
    S_PWR, S_IPRE, S_IREF, S_IMRS, S_IDLE, S_ACT, S_WR, S_BST, S_PRE, S_REF, S_WAIT
  } st_t;

  st_t                 st, ret;
  logic [CNT_W-1:0]    cnt;
  logic [RF_W-1:0]     nref;
  logic [ROW_CNT_W-1:0] row;
  logic [COL_W-1:0]    col;
  logic                tgt;
  logic [LA_W-1:0]     last_wr;
  logic [DATA_W-1:0]   dq_q;
  logic [2:0]          cmd;
  logic                init_ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_PWR;
      ret       <= S_IPRE;
      cnt       <= CNT_W'(PWRUP_CYC - 1);
      nref      <= '0;
      row       <= '0;
      col       <= '0;
      tgt       <= 1'b0;
      last_wr   <= '0;
      last_addr <= '0;
      dq_q      <= '0;
    end else begin
      dq_q <= pix_data;
      if (switch_req) last_addr <= last_wr;
      case (st)
        S_PWR: begin
          if (cnt == '0) st <= S_IPRE;
          else cnt <= cnt - 1'b1;
        end
        S_IPRE: begin
          st  <= S_WAIT;
          cnt <= CNT_W'(T_RP - 2);
          ret <= S_IREF;
        end
        S_IREF: begin
          st  <= S_WAIT;
          cnt <= CNT_W'(T_RFC - 2);
          if (nref == RF_W'(INIT_REFS - 1)) begin
            ret  <= S_IMRS;
            nref <= '0;
          end else begin
            ret  <= S_IREF;
            nref <= nref + 1'b1;
          end
        end
        S_IMRS: begin
          st  <= S_WAIT;
          cnt <= CNT_W'(T_MRD - 2);
          ret <= S_IDLE;
        end
        S_IDLE: begin
          if (line_start) begin
            tgt <= ~rd_sel;
            st  <= S_ACT;
          end
        end
        S_ACT: begin
          st  <= S_WAIT;
          cnt <= CNT_W'(T_RCD - 2);
          ret <= S_WR;
        end
        S_WR: begin
          last_wr <= {row, col};
          if (col == COL_W'(LINE_WORDS - 1)) begin
            col <= '0;
            st  <= S_BST;
          end else begin
            col <= col + 1'b1;
          end
        end
        S_BST: st <= S_PRE;
        S_PRE: begin
          row <= (row == ROW_CNT_W'(ROWS - 1)) ? '0 : row + 1'b1;
          st  <= S_WAIT;
          cnt <= CNT_W'(T_RP - 2);
          ret <= S_REF;
        end
        S_REF: begin
          st  <= S_WAIT;
          cnt <= CNT_W'(T_RFC - 2);
          if (nref == RF_W'(REFS_PER_GAP - 1)) begin
            ret  <= S_IDLE;
            nref <= '0;
          end else begin
            ret  <= S_REF;
            nref <= nref + 1'b1;
          end
        end
        S_WAIT: begin
          if (cnt == '0) st <= ret;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_IPRE, S_PRE: cmd = C_PRE;
      S_IREF, S_REF: cmd = C_REF;
      S_IMRS:        cmd = C_MRS;
      S_ACT:         cmd = C_ACT;
      S_WR:          cmd = (col == '0) ? C_WR : C_NOP;
      S_BST:         cmd = C_BST;
      default:       cmd = C_NOP;
    endcase
  end

  always_comb begin
    addr = '0;
    case (st)
      S_IPRE: addr[10] = 1'b1;
      S_IMRS: addr = MODE_VAL;
      S_ACT:  addr = ADDR_W'(row);
      default: addr = '0;
    endcase
  end

  assign init_ph = (st == S_IPRE) || (st == S_IREF) || (st == S_IMRS);
  assign cs_n    = (cmd == C_NOP) ? 2'b11 : init_ph ? 2'b00 : (tgt ? 2'b01 : 2'b10);
  assign {ras_n, cas_n, we_n} = cmd;
  assign ba      = 2'(BANK);
  assign dq      = dq_q;
  assign dq_oe   = (st == S_WR);
endmodule

module line_writer_chk #(
  parameter int ADDR_W = 12,
  parameter int LA_W   = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              dq_oe,
  input logic              switch_req,
  input logic [LA_W-1:0]   last_addr
);
  logic       sel;
  logic [2:0] c;
  assign sel = (cs_n != 2'b11);
  assign c   = {ras_n, cas_n, we_n};

  // R4
  wr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (sel && c == 3'b100));
  // R3
  wr_col0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && c == 3'b100) |-> (addr == '0 && ba == 2'b00 && dq_oe));
  // R5
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (sel && c == 3'b110));
  // R5
  bst_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && c == 3'b110) |=> (sel && c == 3'b010 && !addr[10]));
  // R6
  ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && c == 3'b001) |=> !sel);
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_req |=> $stable(last_addr));
endmodule

bind sdram_line_writer line_writer_chk #(.ADDR_W(ADDR_W), .LA_W(LA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .addr(addr), .dq_oe(dq_oe),
  .switch_req(switch_req), .last_addr(last_addr));

// File: tb/sdram_line_writer_bench.sv
module sdram_line_writer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LW    = 1024;
  localparam int NROWS = 4;
  localparam int PWR   = 50;
  localparam int TRP   = 2;
  localparam int TRFC  = 8;
  localparam int TMRD  = 2;
  localparam int TRCD  = 2;
  localparam int REFS  = 25;
  localparam int AW    = 12;
  localparam int LAW   = 12;
  localparam int NLINES = 6;

  localparam logic [2:0] C_ACT = 3'b011, C_WR = 3'b100, C_BST = 3'b110,
                         C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000;

  logic clk, rst_n, line_start, rd_sel, switch_req;
  logic [7:0] pix_data;
  logic [1:0] cs_n, ba;
  logic ras_n, cas_n, we_n, dq_oe;
  logic [AW-1:0] addr;
  logic [7:0] dq;
  logic [LAW-1:0] last_addr;

  sdram_line_writer #(
    .LINE_WORDS(LW), .ROWS(NROWS), .ADDR_W(AW), .DATA_W(8), .PWRUP_CYC(PWR),
    .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD), .T_RCD(TRCD), .CAS_LAT(2),
    .REFS_PER_GAP(REFS), .BANK(0)
  ) u_sdram_line_writer (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_data(pix_data),
    .rd_sel(rd_sel), .switch_req(switch_req), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dq(dq), .dq_oe(dq_oe),
    .last_addr(last_addr));

  typedef struct { int cyc; logic [2:0] cmd; logic [1:0] cs; logic [AW-1:0] a; logic [1:0] b; } cmd_e;
  typedef struct { int chip; int row; int col; int data; } word_e;

  cmd_e  cmd_log[$];
  word_e exp_q[$];
  int    ls_cyc[$];
  int    ls_chip[$];
  int    cyc, n_chk, n_fail;
  int    mrow, mcol, mchip;
  bit    init_seen, early_oe;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  function automatic int pix(int li, int k);
    return (li * 37 + k * 5 + (k >> 3)) & 255;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n != 2'b11) begin
        cmd_log.push_back('{cyc, {ras_n, cas_n, we_n}, cs_n, addr, ba});
        if ({ras_n, cas_n, we_n} == C_MRS) init_seen = 1'b1;
        if ({ras_n, cas_n, we_n} == C_ACT) mrow = int'(addr);
      end
      if (dq_oe) begin
        if (!init_seen) early_oe = 1'b1;
        if (cs_n != 2'b11 && {ras_n, cas_n, we_n} == C_WR) begin
          mcol  = 0;
          mchip = (cs_n == 2'b01) ? 1 : 0;
        end else begin
          mcol = mcol + 1;
        end
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected word", mcol, -1);
        end else begin
          word_e e;
          e = exp_q.pop_front();
          check(int'(dq) == e.data, "R4", "word data", int'(dq), e.data);
          check(mcol == e.col, "R4", "word column", mcol, e.col);
          check(mrow == e.row, "R7", "word row", mrow, e.row);
          check(mchip == e.chip, "R8", "word chip", mchip, e.chip);
        end
      end
    end
  end

  task automatic send_line(int li, bit rs, bit flip);
    int chip;
    chip = rs ? 0 : 1;
    @(negedge clk);
    rd_sel = rs;
    line_start = 1'b1;
    ls_cyc.push_back(cyc);
    ls_chip.push_back(chip);
    for (int k = 0; k < LW; k++) exp_q.push_back('{chip, li % NROWS, k, pix(li, k)});
    @(negedge clk);
    line_start = 1'b0;
    repeat (TRCD - 1) @(negedge clk);
    for (int k = 0; k < LW; k++) begin
      pix_data = 8'(pix(li, k));
      if (flip && k == LW / 2) rd_sel = ~rs;
      @(negedge clk);
    end
    pix_data = 8'h00;
    repeat (230) @(negedge clk);
  endtask

  task automatic pulse_switch(int exp, string what);
    @(negedge clk);
    switch_req = 1'b1;
    @(negedge clk);
    switch_req = 1'b0;
    check(int'(last_addr) == exp, "R9", what, int'(last_addr), exp);
  endtask

  task automatic analyze();
    int idx;
    bit ok;
    check(cmd_log.size() >= 4, "R2", "init command count", cmd_log.size(), 4);
    if (cmd_log.size() < 4) return;
    check(cmd_log[0].cyc >= PWR, "R1", "first command cycle", cmd_log[0].cyc, PWR);
    check(!early_oe, "R1", "data driven before init", int'(early_oe), 0);
    check(cmd_log[0].cmd == C_PRE && cmd_log[0].cs == 2'b00 && cmd_log[0].a[10],
          "R2", "precharge-all", int'(cmd_log[0].cmd), int'(C_PRE));
    check(cmd_log[1].cmd == C_REF && cmd_log[1].cs == 2'b00 && cmd_log[1].cyc - cmd_log[0].cyc >= TRP,
          "R2", "first init refresh", cmd_log[1].cyc - cmd_log[0].cyc, TRP);
    check(cmd_log[2].cmd == C_REF && cmd_log[2].cs == 2'b00 && cmd_log[2].cyc - cmd_log[1].cyc >= TRFC,
          "R2", "second init refresh", cmd_log[2].cyc - cmd_log[1].cyc, TRFC);
    check(cmd_log[3].cmd == C_MRS && cmd_log[3].cs == 2'b00 && cmd_log[3].cyc - cmd_log[2].cyc >= TRFC,
          "R2", "mode set order", int'(cmd_log[3].cmd), int'(C_MRS));
    check(int'(cmd_log[3].a) == 'h027, "R2", "mode value", int'(cmd_log[3].a), 'h027);
    idx = 4;
    for (int L = 0; L < NLINES; L++) begin
      logic [1:0] ecs;
      int ac, wc, bc, pc;
      ecs = (ls_chip[L] == 1) ? 2'b01 : 2'b10;
      if (idx + 4 + REFS > cmd_log.size()) begin
        check(1'b0, "R6", "command log short", cmd_log.size(), idx + 4 + REFS);
        return;
      end
      ac = cmd_log[idx].cyc; wc = cmd_log[idx+1].cyc;
      bc = cmd_log[idx+2].cyc; pc = cmd_log[idx+3].cyc;
      check(cmd_log[idx].cmd == C_ACT && ac == ls_cyc[L] + 1 && cmd_log[idx].b == 2'b00,
            "R3", "active timing", ac, ls_cyc[L] + 1);
      check(int'(cmd_log[idx].a) == L % NROWS, "R7", "active row", int'(cmd_log[idx].a), L % NROWS);
      check(cmd_log[idx].cs == ecs, "R8", "active chip select", int'(cmd_log[idx].cs), int'(ecs));
      check(cmd_log[idx+1].cmd == C_WR && wc == ac + TRCD && cmd_log[idx+1].a == '0,
            "R3", "write timing", wc, ac + TRCD);
      check(cmd_log[idx+2].cmd == C_BST && bc == wc + LW, "R5", "burst terminate", bc, wc + LW);
      check(cmd_log[idx+3].cmd == C_PRE && pc == bc + 1 && !cmd_log[idx+3].a[10]
            && cmd_log[idx+3].cs == ecs, "R5", "line precharge", pc, bc + 1);
      ok = 1'b1;
      for (int r = 0; r < REFS; r++) begin
        cmd_e e;
        e = cmd_log[idx+4+r];
        if (e.cmd != C_REF || e.cyc != pc + TRP + r * TRFC || e.cs != ecs) ok = 1'b0;
      end
      check(ok, "R6", "gap refresh train", int'(ok), 1);
      check(ok, "R8", "gap refresh chip", int'(ok), 1);
      idx += 4 + REFS;
    end
    check(idx == cmd_log.size(), "R6", "extra commands", cmd_log.size(), idx);
    check(exp_q.size() == 0, "R4", "words not written", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; init_seen = 1'b0; early_oe = 1'b0;
    mrow = 0; mcol = 0; mchip = 0;
    rst_n = 1'b0; line_start = 1'b0; rd_sel = 1'b0; switch_req = 1'b0; pix_data = 8'h00;
    repeat (5) @(negedge clk);
    check(cs_n == 2'b11 && !dq_oe, "R1", "reset outputs", int'(cs_n), 3);
    rst_n = 1'b1;
    repeat (PWR + 60) @(negedge clk);
    pulse_switch(0, "before any write");
    send_line(0, 1'b0, 1'b0);
    send_line(1, 1'b0, 1'b0);
    send_line(2, 1'b0, 1'b1);
    pulse_switch(2 * LW + LW - 1, "after line 2");
    send_line(3, 1'b1, 1'b0);
    check(int'(last_addr) == 2 * LW + LW - 1, "R9", "hold without request",
          int'(last_addr), 2 * LW + LW - 1);
    send_line(4, 1'b1, 1'b0);
    send_line(5, 1'b0, 1'b0);
    pulse_switch(1 * LW + LW - 1, "after wrapped line");
    repeat (20) @(negedge clk);
    analyze();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule